// File: doc/BRIEF.md
# Programmable Logic Cell with Octet Configuration

This block is a behavioural model of one programmable logic cell. A small write port loads its configuration one 8-bit octet at a time, addressed by a sub-address. The cell holds two 3-input lookup tables, named X and Y. Both tables share the X and Y inputs. Their third input comes from a selectable mux.

A register takes its data from either lookup table or from the raw Z input. The Z input can also bypass the register and reach the centre output and the feedback line. The centre output can in turn replace either neighbour output.

The X, Y, W and Z inputs arrive already resolved from routing. The outputs are the X and Y neighbour outputs and the feedback line. The register has a clock edge capture and a separate asynchronous set/reset request. A configuration bit chooses whether that request presets or clears the register.

Top module: `logic_cell_model`

## Requirements
- R1: A write commits at a rising `clk` edge when `cfg_we` is high. It is accepted only when `cfg_addr[7:4]` is 0000. Accepted sub-addresses are 1 (route octet), 6 (X table), 7 (Y table) and 10 (register mode octet). Any other address changes no stored state.
- R2: While `rst_n` is low, the route and mode octets read all ones and both table octets read zero. The register holds 0.
- R3: Table octets are stored inverted. A table output is the complement of the stored bit at index {in_x, in_y, third}, where in_x is index bit 2 and the third input is bit 0.
- R4: The third table input comes from route bit 5 (W AND Z) or route bit 4 (feedback line). Bit 5 wins over bit 4. When both bits are 0, raw `in_w` is used.
- R5: At each rising edge without a set/reset request, the register loads a value chosen by route bits 7 and 6. Bit 7 selects `in_z` and wins over bit 6. Bit 6 selects the Y table. With both bits 0, the X table is loaded.
- R6: Route bit 3 makes the centre output equal to `in_z`; otherwise the centre output is the register. Route bit 2 does the same for `out_fb`.
- R7: When route bit 1 is high, `out_x` carries the centre output; otherwise it carries the X table. Route bit 0 does the same for `out_y` and the Y table.
- R8: The W AND Z term feeds the third table input as the logical AND of `in_w` and `in_z`.
- R9: While `sr_req` is high, the register is forced at once and ignores clock edges. Mode octet bit 3 sets the forced value: 0 presets it to 1, and 1 clears it to 0.
- R10: A configuration write changes the outputs from the cycle after its committing edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes and register capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration sub-address |
| cfg_wdata | input | 8 | Configuration octet |
| in_x | input | 1 | Resolved X input |
| in_y | input | 1 | Resolved Y input |
| in_w | input | 1 | Resolved W input |
| in_z | input | 1 | Resolved Z input |
| sr_req | input | 1 | Asynchronous set/reset request, active high |
| out_x | output | 1 | X neighbour output |
| out_y | output | 1 | Y neighbour output |
| out_fb | output | 1 | Feedback line |

## Verification
The bench writes tables for AND, XOR and multiplexer functions. A design that forgot the inversion would return the complement of every truth value. It clears the route octet to check the default paths: raw W into the tables and the X table into the register. A design with the wrong default would show the Y table or Z at the feedback output one cycle later. It also sets both route bits of each select pair to test priority. It pulses `sr_req` under both mode values; a swapped polarity would show the opposite constant on the feedback line. Writes to addresses with a nonzero upper nibble are mixed into random traffic, and a design that decoded only the low nibble would overwrite live configuration.

// File: rtl/cell_cfg_pkg.sv
package cell_cfg_pkg;
   localparam int OCT_W = 8;
   localparam logic [3:0] SUB_ROUTE = 4'd1;
   localparam logic [3:0] SUB_XTAB  = 4'd6;
   localparam logic [3:0] SUB_YTAB  = 4'd7;
   localparam logic [3:0] SUB_MODE  = 4'd10;
   localparam int MODE_CLR_BIT = 3;

   typedef struct packed {
      logic z_to_reg;
      logic y_to_reg;
      logic wz_to_w;
      logic fb_to_w;
      logic z_to_c;
      logic z_to_fb;
      logic c_to_xo;
      logic c_to_yo;
   } route_t;
endpackage

// File: rtl/cell_cfg_bank.sv
module cell_cfg_bank
   import cell_cfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int SUB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] route_oct,
   output logic [DATA_W-1:0] xtab_oct,
   output logic [DATA_W-1:0] ytab_oct,
   output logic [DATA_W-1:0] mode_oct
);
   localparam int HI_W = ADDR_W - SUB_W;

   if (HI_W < 1) begin : g_bad_addr
      $error("cell_cfg_bank: ADDR_W must exceed SUB_W");
   end
   if (DATA_W != OCT_W) begin : g_bad_data
      $error("cell_cfg_bank: DATA_W must be one octet");
   end

   logic            hit;
   logic [SUB_W-1:0] sub;

   assign sub = addr[SUB_W-1:0];
   assign hit = we && (addr[ADDR_W-1:SUB_W] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_oct <= '1;
         mode_oct  <= '1;
         xtab_oct  <= '0;
         ytab_oct  <= '0;
      end else if (hit) begin
         if (sub == SUB_W'(SUB_ROUTE)) route_oct <= wdata;
         if (sub == SUB_W'(SUB_XTAB))  xtab_oct  <= wdata;
         if (sub == SUB_W'(SUB_YTAB))  ytab_oct  <= wdata;
         if (sub == SUB_W'(SUB_MODE))  mode_oct  <= wdata;
      end
   end
endmodule

// File: rtl/cell_lut.sv
module cell_lut #(
   parameter int K = 3
) (
   input  logic [(1<<K)-1:0] tab_inv,
   input  logic [K-1:0]      sel,
   output logic              y
);
   if (K < 1 || K > 6) begin : g_bad_k
      $error("cell_lut: K out of range");
   end
   assign y = ~tab_inv[sel];
endmodule

// File: rtl/cell_reg.sv
module cell_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic sr_req,
   input  logic clr_mode,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n or posedge sr_req) begin
      if (!rst_n)      q <= 1'b0;
      else if (sr_req) q <= ~clr_mode;
      else             q <= d;
   end
endmodule

// File: rtl/logic_cell_model.sv
module logic_cell_model
   import cell_cfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int LUT_K  = 3,
   parameter int N_LUT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              in_x,
   input  logic              in_y,
   input  logic              in_w,
   input  logic              in_z,
   input  logic              sr_req,
   output logic              out_x,
   output logic              out_y,
   output logic              out_fb
);
   localparam int TAB_N = 1 << LUT_K;

   if (TAB_N != DATA_W) begin : g_bad_tab
      $error("logic_cell_model: one table must fill one octet");
   end
   if (N_LUT != 2) begin : g_bad_nlut
      $error("logic_cell_model: cell has exactly an X and a Y table");
   end

   logic [DATA_W-1:0] route_oct, mode_oct;
   logic [N_LUT-1:0][DATA_W-1:0] tabs;
   logic [N_LUT-1:0] lut_y;
   route_t rt;
   logic w_and_z, third_in, reg_d, reg_q, centre, fb_line;
   logic [LUT_K-1:0] lut_sel;

   cell_cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_W(4)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .route_oct(route_oct),
      .xtab_oct (tabs[0]),
      .ytab_oct (tabs[1]),
      .mode_oct (mode_oct)
   );

   assign rt = route_t'(route_oct[OCT_W-1:0]);

   assign w_and_z = in_w & in_z;

   always_comb begin
      if (rt.wz_to_w)      third_in = w_and_z;
      else if (rt.fb_to_w) third_in = fb_line;
      else                 third_in = in_w;
   end

   assign lut_sel = {in_x, in_y, third_in};

   for (genvar g = 0; g < N_LUT; g++) begin : g_lut
      cell_lut #(.K(LUT_K)) u_lut (
         .tab_inv(tabs[g]),
         .sel    (lut_sel),
         .y      (lut_y[g])
      );
   end

   always_comb begin
      if (rt.z_to_reg)      reg_d = in_z;
      else if (rt.y_to_reg) reg_d = lut_y[1];
      else                  reg_d = lut_y[0];
   end

   cell_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sr_req  (sr_req),
      .clr_mode(mode_oct[MODE_CLR_BIT]),
      .d       (reg_d),
      .q       (reg_q)
   );

   assign centre  = rt.z_to_c  ? in_z : reg_q;
   assign fb_line = rt.z_to_fb ? in_z : reg_q;

   assign out_x  = rt.c_to_xo ? centre : lut_y[0];
   assign out_y  = rt.c_to_yo ? centre : lut_y[1];
   assign out_fb = fb_line;
endmodule

// File: rtl/cell_chk.sv
module cell_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [7:0] cfg_addr,
   input logic [7:0] route_oct,
   input logic [7:0] mode_oct,
   input logic [7:0] xtab,
   input logic       sr_req,
   input logic       reg_d,
   input logic       reg_q,
   input logic       in_x,
   input logic       in_y,
   input logic       in_w,
   input logic       in_z,
   input logic       out_x,
   input logic       out_fb
);
   // R1
   foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr[7:4] != 4'h0) |=> ($stable(route_oct) && $stable(mode_oct) && $stable(xtab)));

   // R9
   sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_req && $stable(mode_oct)) |-> (reg_q == ~mode_oct[3]));

   // R5
   reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n || sr_req)
      !sr_req |=> (reg_q == $past(reg_d)));

   // R6
   fb_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_oct[2] |-> (out_fb == in_z));

   // R7
   xo_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_oct[1] && route_oct[3]) |-> (out_x == in_z));

   // R3
   x_table_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!route_oct[1] && !route_oct[5] && !route_oct[4]) |-> (out_x == ~xtab[{in_x, in_y, in_w}]));
endmodule

bind logic_cell_model cell_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .route_oct(route_oct),
   .mode_oct (mode_oct),
   .xtab     (tabs[0]),
   .sr_req   (sr_req),
   .reg_d    (reg_d),
   .reg_q    (reg_q),
   .in_x     (in_x),
   .in_y     (in_y),
   .in_w     (in_w),
   .in_z     (in_z),
   .out_x    (out_x),
   .out_fb   (out_fb)
);

// File: tb/sim_logic_cell_model.sv
module sim_logic_cell_model;
   localparam int CLK_P = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [7:0] cfg_addr = '0, cfg_wdata = '0;
   logic in_x = 0, in_y = 0, in_w = 0, in_z = 0, sr_req = 0;
   logic out_x, out_y, out_fb;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0] m_route, m_xt, m_yt, m_mode;
   logic m_q;

   always #(CLK_P/2) clk = ~clk;

   logic_cell_model u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_x(in_x), .in_y(in_y), .in_w(in_w),
      .in_z(in_z), .sr_req(sr_req), .out_x(out_x), .out_y(out_y), .out_fb(out_fb)
   );

   function automatic logic f_fb();
      return m_route[2] ? in_z : m_q;
   endfunction
   function automatic logic f_centre();
      return m_route[3] ? in_z : m_q;
   endfunction
   function automatic logic f_third();
      if (m_route[5]) return in_w & in_z;
      if (m_route[4]) return f_fb();
      return in_w;
   endfunction
   function automatic logic f_lut(input logic [7:0] t);
      return ~t[{in_x, in_y, f_third()}];
   endfunction
   function automatic logic f_d();
      if (m_route[7]) return in_z;
      if (m_route[6]) return f_lut(m_yt);
      return f_lut(m_xt);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, out_x,  m_route[1] ? f_centre() : f_lut(m_xt));
      chk(req, out_y,  m_route[0] ? f_centre() : f_lut(m_yt));
      chk(req, out_fb, f_fb());
   endtask

   // one cycle: drive at negedge, check, then take the edge
   task automatic cycle(input logic [3:0] ins, input logic we, input logic [7:0] a,
                        input logic [7:0] dat, input string req);
      logic dn;
      {in_x, in_y, in_w, in_z} = ins;
      cfg_we = we; cfg_addr = a; cfg_wdata = dat;
      #(CLK_P/4);
      check_all(req);
      dn = f_d();
      @(posedge clk);
      if (!sr_req) m_q = dn;
      if (we && a[7:4] == 4'h0) begin
         case (a[3:0])
            4'd1:  m_route = dat;
            4'd6:  m_xt    = dat;
            4'd7:  m_yt    = dat;
            4'd10: m_mode  = dat;
            default: ;
         endcase
      end
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] dat);
      cycle(4'h0, 1'b1, a, dat, "R10");
   endtask

   task automatic pulse_sr(input string req);
      sr_req = 1;
      #1;
      m_q = ~m_mode[3];
      #1;
      chk(req, out_fb, f_fb());
      @(negedge clk);
      check_all(req);
      sr_req = 0;
      #1;
   endtask

   initial begin
      #(CLK_P * 50000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      m_route = '1; m_mode = '1; m_xt = '0; m_yt = '0; m_q = 0;
      repeat (3) @(negedge clk);
      // R2: reset values, all outputs follow Z through the centre/bypass
      in_z = 1; #1; chk("R2", out_x, 1'b1); chk("R2", out_fb, 1'b1);
      in_z = 0; #1; chk("R2", out_y, 1'b0);
      rst_n = 1;
      @(negedge clk);
      // R10: route all-zero takes effect next cycle
      cycle(4'b0001, 1'b1, 8'h01, 8'h00, "R10");
      chk("R10", out_fb, m_q);
      // R3: AND table stored inverted, Y = XOR
      wr(8'h06, 8'h7F);
      wr(8'h07, 8'h69);
      for (int i = 0; i < 16; i++) cycle(4'(i), 1'b0, 8'h00, 8'h00, "R3");
      chk("R3", out_x, 1'b1);
      // MUX table: x ? y : w
      wr(8'h06, 8'h35);
      for (int i = 0; i < 16; i++) cycle(4'(i), 1'b0, 8'h00, 8'h00, "R4");
      // R8: W AND Z into third input
      wr(8'h01, 8'h20);
      for (int i = 0; i < 16; i++) cycle(4'(i), 1'b0, 8'h00, 8'h00, "R8");
      // R4: priority WZ over FB
      wr(8'h01, 8'h30);
      for (int i = 0; i < 8; i++) cycle(4'(i), 1'b0, 8'h00, 8'h00, "R4");
      wr(8'h01, 8'h10);
      for (int i = 0; i < 8; i++) cycle(4'(i * 3), 1'b0, 8'h00, 8'h00, "R4");
      // R5: register sources and priority
      wr(8'h01, 8'h40);
      for (int i = 0; i < 8; i++) cycle(4'(i * 5), 1'b0, 8'h00, 8'h00, "R5");
      wr(8'h01, 8'hC0);
      for (int i = 0; i < 8; i++) cycle(4'(i * 7), 1'b0, 8'h00, 8'h00, "R5");
      // R6/R7: bypass and centre outputs
      wr(8'h01, 8'h0F);
      for (int i = 0; i < 4; i++) cycle(4'(i), 1'b0, 8'h00, 8'h00, "R6");
      wr(8'h01, 8'h03);
      for (int i = 0; i < 4; i++) cycle(4'(i + 1), 1'b0, 8'h00, 8'h00, "R7");
      // R9: both polarities, route reads register on fb
      wr(8'h01, 8'h00);
      wr(8'h0A, 8'h08);
      pulse_sr("R9");
      cycle(4'h0, 1'b0, 8'h00, 8'h00, "R9");
      wr(8'h0A, 8'h00);
      pulse_sr("R9");
      // R1: foreign addresses leave state untouched
      wr(8'h11, 8'hFF);
      wr(8'hF6, 8'h00);
      wr(8'h05, 8'hAA);
      for (int i = 0; i < 16; i++) cycle(4'(i), 1'b0, 8'h00, 8'h00, "R1");
      // random traffic
      for (int n = 0; n < 600; n++) begin
         logic [7:0] a;
         logic [31:0] r;
         r = $urandom;
         case (r[2:0])
            3'd0: a = 8'h01;
            3'd1: a = 8'h06;
            3'd2: a = 8'h07;
            3'd3: a = 8'h0A;
            3'd4: a = {4'(r[11:8] | 4'h1), r[15:12]};
            default: a = {4'h0, r[15:12]};
         endcase
         cycle(r[19:16], r[20], a, r[31:24], "R1");
         if (r[23:21] == 3'd0) pulse_sr("R9");
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule